// File: doc/BRIEF.md
# Mode-Aware Opcode Pre-Decoder

This block sits at the front of an instruction decoder and classifies a byte stream of x86 machine code, one byte per cycle, under the control of a mode input. The mode input selects either the legacy 32-bit interpretation or 64-bit long mode. Bytes enter through a valid/ready handshake. The block absorbs operand-size and REX prefixes, reads the opcode byte, and reads a ModRM byte when the opcode has one. It then publishes one result record per instruction. The record holds an operation class, a destination register number, the effective operand size and an invalid-opcode flag.

The same byte values take different meanings in the two modes. In 64-bit mode the 0x40..0x4F range stops being single-byte increment and decrement and becomes the REX prefix. Opcode 0x63 changes from ARPL to MOVSXD. Segment push/pop of the four older segment registers and the BCD adjust opcodes become invalid. Immediates, displacements, SIB bytes and memory operands are not consumed. The mode input is expected to stay stable while an instruction is in progress.

Top module: `opc_predecode`

## Requirements
- R1: With `mode64`=0, opcode 0x40..0x47 yields class INC (1) and 0x48..0x4F yields class DEC (2). The destination register is bits [2:0] of the byte and the record is valid.
- R2: With `mode64`=1, a byte 0x40..0x4F produces no record and `in_ready` stays high. Its bits W=bit3, R=bit2, B=bit0 are kept for the following opcode.
- R3: Opcode 0xFF plus ModRM yields INC (1) when ModRM bits [5:3] are 0 and DEC (2) when they are 1, and OTHER (0) for any other value. The register is {REX.B, ModRM[2:0]} and the record is valid in both modes.
- R4: Opcode 0x63 plus ModRM yields ARPL (4) in legacy mode, with register ModRM[2:0] and size 16. In 64-bit mode it yields MOVSXD (3), with register {REX.R, ModRM[5:3]} and the size given by R9.
- R5: Opcodes 0x06/0x0E/0x16/0x1E yield SEG_PUSH (5) and 0x07/0x17/0x1F yield SEG_POP (6). The register is the segment number ES=0, CS=1, SS=2, DS=3. The invalid flag equals `mode64`.
- R6: 0x0F 0xA0 and 0x0F 0xA8 yield SEG_PUSH, and 0x0F 0xA1 and 0x0F 0xA9 yield SEG_POP. The register is FS=4 or GS=5 and the record is valid in both modes. Any other byte after 0x0F yields OTHER with register 0.
- R7: Opcodes 0x27, 0x2F, 0x37, 0x3F, 0xD4 and 0xD5 yield BCD (9) with register 0. The invalid flag equals `mode64`.
- R8: 0x9E yields FLAG_STORE (7) and 0x9F yields FLAG_LOAD (8), with register 0. Both are valid in both modes.
- R9: Size codes are 0=16, 1=32 and 2=64. An effective REX with W=1 in 64-bit mode gives 64. Otherwise a 0x66 prefix gives 16, and otherwise the size is 32.
- R10: A REX prefix counts only when it is the last prefix before the opcode. A 0x66 that follows a REX discards it, and a later REX replaces an earlier one.
- R11: A record stays on the outputs unchanged until `out_ready` accepts it. While a record is held, `in_ready` is low and no byte is consumed.
- R12: The synchronous active-high `rst` clears any held record, pending prefixes and partial instruction. Decoding resumes in the prefix/opcode scan.
- R13: Any other single-byte opcode yields OTHER (0) with register 0 and the invalid flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode64 | input | 1 | 1 = 64-bit long mode, 0 = legacy 32-bit |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | Result record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_class | output | 4 | Operation class code |
| out_reg | output | 4 | Destination register number |
| out_size | output | 2 | Effective operand size code |
| out_invalid | output | 1 | Invalid-opcode flag |

## Verification
The bench sweeps every opcode byte in both modes, and every ModRM value after 0xFF, 0x63 and 0x0F. A design that kept decoding 0x4x as INC/DEC in 64-bit mode would emit a record where none is due. One that flagged the wrong segment opcodes would report a wrong invalid flag on FS/GS or the older segment registers. Prefix orderings check that a REX followed by 0x66 is dropped and that a second REX wins; a design that latched REX once would report a 64-bit size or an extended register wrongly. A held-record test presents bytes while `out_ready` is low, and a mid-instruction reset test catches leftover prefix or ModRM-pending state.

// File: rtl/predec_pkg.sv
package predec_pkg;
  localparam int BYTE_W = 8;
  localparam int RNUM_W = 4;

  typedef enum logic [3:0] {
    C_OTHER      = 4'd0,
    C_INC        = 4'd1,
    C_DEC        = 4'd2,
    C_MOVSXD     = 4'd3,
    C_ARPL       = 4'd4,
    C_SEG_PUSH   = 4'd5,
    C_SEG_POP    = 4'd6,
    C_FLAG_STORE = 4'd7,
    C_FLAG_LOAD  = 4'd8,
    C_BCD        = 4'd9
  } op_class_e;

  typedef enum logic [1:0] {
    SZ16 = 2'd0,
    SZ32 = 2'd1,
    SZ64 = 2'd2
  } op_size_e;

  // what a byte seen in the scan state means
  typedef enum logic [2:0] {
    K_FINAL, K_OSZ, K_REX, K_ESC, K_GRP, K_SXD
  } byte_kind_e;

  typedef struct packed {
    op_class_e        cls;
    logic [RNUM_W-1:0] rnum;
    op_size_e         size;
    logic             inv;
  } pd_rec_t;

  localparam logic [BYTE_W-1:0] OPSZ_BYTE = 8'h66;
endpackage

// File: rtl/predec_opmap.sv
// Classifies a byte seen in the prefix/opcode scan state.
module predec_opmap
  import predec_pkg::*;
(
  input  logic              mode64,
  input  logic [BYTE_W-1:0] opc,
  output byte_kind_e        kind,
  output op_class_e         cls,
  output logic [2:0]        rnum,
  output logic              inv
);
  always_comb begin
    kind = K_FINAL;
    cls  = C_OTHER;
    rnum = 3'd0;
    inv  = 1'b0;
    if (opc == OPSZ_BYTE) begin
      kind = K_OSZ;
    end else if (opc[7:4] == 4'h4) begin
      if (mode64) begin
        kind = K_REX;
      end else begin
        cls  = opc[3] ? C_DEC : C_INC;
        rnum = opc[2:0];
      end
    end else begin
      case (opc)
        8'h0F: kind = K_ESC;
        8'hFF: kind = K_GRP;
        8'h63: kind = K_SXD;
        8'h06, 8'h0E, 8'h16, 8'h1E: begin
          cls  = C_SEG_PUSH;
          rnum = {1'b0, opc[4:3]};
          inv  = mode64;
        end
        8'h07, 8'h17, 8'h1F: begin
          cls  = C_SEG_POP;
          rnum = {1'b0, opc[4:3]};
          inv  = mode64;
        end
        8'h27, 8'h2F, 8'h37, 8'h3F, 8'hD4, 8'hD5: begin
          cls = C_BCD;
          inv = mode64;
        end
        8'h9E: cls = C_FLAG_STORE;
        8'h9F: cls = C_FLAG_LOAD;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/predec_esc.sv
// Second byte after the 0x0F escape.
module predec_esc
  import predec_pkg::*;
(
  input  logic [BYTE_W-1:0] b,
  output op_class_e         cls,
  output logic [2:0]        rnum
);
  always_comb begin
    cls  = C_OTHER;
    rnum = 3'd0;
    case (b)
      8'hA0, 8'hA8: begin cls = C_SEG_PUSH; rnum = b[5:3]; end
      8'hA1, 8'hA9: begin cls = C_SEG_POP;  rnum = b[5:3]; end
      default: ;
    endcase
  end
endmodule

// File: rtl/predec_modrm.sv
// ModRM byte after 0xFF (group) or 0x63 (ARPL / MOVSXD).
module predec_modrm
  import predec_pkg::*;
(
  input  logic              mode64,
  input  logic              is_sxd,
  input  logic              rex_r,
  input  logic              rex_b,
  input  logic [2:0]        rf,
  input  logic [2:0]        rm,
  output op_class_e         cls,
  output logic [RNUM_W-1:0] rnum,
  output logic              force16
);
  always_comb begin
    force16 = 1'b0;
    if (is_sxd) begin
      if (mode64) begin
        cls  = C_MOVSXD;
        rnum = {rex_r, rf};
      end else begin
        cls     = C_ARPL;
        rnum    = {1'b0, rm};
        force16 = 1'b1;
      end
    end else begin
      case (rf)
        3'd0:    cls = C_INC;
        3'd1:    cls = C_DEC;
        default: cls = C_OTHER;
      endcase
      rnum = {rex_b, rm};
    end
  end
endmodule

// File: rtl/opc_predecode.sv
module opc_predecode
  import predec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mode64,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_class,
  output logic [RNUM_W-1:0] out_reg,
  output logic [1:0]        out_size,
  output logic              out_invalid
);
  typedef enum logic [1:0] {ST_SCAN, ST_ESC, ST_MODRM} st_e;

  st_e     state;
  logic    osz, rex_ok, rex_w, rex_r, rex_b, pend_sxd;
  pd_rec_t out_rec, rec_d;
  logic    accept, emit;

  byte_kind_e om_kind;
  op_class_e  om_cls, es_cls, md_cls;
  logic [2:0] om_rnum, es_rnum;
  logic [RNUM_W-1:0] md_rnum;
  logic       om_inv, md_f16;
  logic       rex_live;
  op_size_e   sz_norm;

  assign in_ready = !out_valid;
  assign accept   = in_valid && in_ready;
  assign rex_live = rex_ok && mode64;

  predec_opmap u_opmap (
    .mode64(mode64), .opc(in_byte),
    .kind(om_kind), .cls(om_cls), .rnum(om_rnum), .inv(om_inv)
  );

  predec_esc u_esc (.b(in_byte), .cls(es_cls), .rnum(es_rnum));

  predec_modrm u_modrm (
    .mode64(mode64), .is_sxd(pend_sxd),
    .rex_r(rex_r && rex_live), .rex_b(rex_b && rex_live),
    .rf(in_byte[5:3]), .rm(in_byte[2:0]),
    .cls(md_cls), .rnum(md_rnum), .force16(md_f16)
  );

  always_comb begin
    if (rex_live && rex_w) sz_norm = SZ64;
    else if (osz)          sz_norm = SZ16;
    else                   sz_norm = SZ32;
  end

  always_comb begin
    rec_d = '{cls: C_OTHER, rnum: '0, size: sz_norm, inv: 1'b0};
    emit  = 1'b0;
    case (state)
      ST_SCAN: begin
        rec_d.cls  = om_cls;
        rec_d.rnum = {1'b0, om_rnum};
        rec_d.inv  = om_inv;
        emit       = accept && (om_kind == K_FINAL);
      end
      ST_ESC: begin
        rec_d.cls  = es_cls;
        rec_d.rnum = {1'b0, es_rnum};
        emit       = accept;
      end
      ST_MODRM: begin
        rec_d.cls  = md_cls;
        rec_d.rnum = md_rnum;
        if (md_f16) rec_d.size = SZ16;
        emit       = accept;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_SCAN;
      osz       <= 1'b0;
      rex_ok    <= 1'b0;
      rex_w     <= 1'b0;
      rex_r     <= 1'b0;
      rex_b     <= 1'b0;
      pend_sxd  <= 1'b0;
      out_valid <= 1'b0;
      out_rec   <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (emit) begin
        out_valid <= 1'b1;
        out_rec   <= rec_d;
        state     <= ST_SCAN;
        osz       <= 1'b0;
        rex_ok    <= 1'b0;
      end else if (accept && state == ST_SCAN) begin
        case (om_kind)
          K_OSZ: begin
            osz    <= 1'b1;
            rex_ok <= 1'b0;   // REX must sit right before the opcode
          end
          K_REX: begin
            rex_ok <= 1'b1;
            rex_w  <= in_byte[3];
            rex_r  <= in_byte[2];
            rex_b  <= in_byte[0];
          end
          K_ESC: state <= ST_ESC;
          K_GRP: begin state <= ST_MODRM; pend_sxd <= 1'b0; end
          K_SXD: begin state <= ST_MODRM; pend_sxd <= 1'b1; end
          default: ;
        endcase
      end
    end
  end

  assign out_class   = out_rec.cls;
  assign out_reg     = out_rec.rnum;
  assign out_size    = out_rec.size;
  assign out_invalid = out_rec.inv;

  // R11: a record not taken stays put
  a_r11_hold_stable: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_rec));

  // R1: legacy 0x4x opcode produces INC/DEC of its low register bits
  a_r1_legacy_incdec: assert property (@(posedge clk) disable iff (rst)
    accept && state == ST_SCAN && !mode64 && in_byte[7:4] == 4'h4
    |=> out_valid && (out_class == 4'd1 || out_class == 4'd2)
        && out_reg == {1'b0, $past(in_byte[2:0])});

  // R2: a REX byte in long mode yields no record
  a_r2_rex_silent: assert property (@(posedge clk) disable iff (rst)
    accept && state == ST_SCAN && mode64 && in_byte[7:4] == 4'h4
    |=> !out_valid);

  // R5 / R7: only segment and BCD classes can carry the invalid flag
  a_r5_invalid_classes: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_invalid |->
      out_class == 4'd5 || out_class == 4'd6 || out_class == 4'd9);

  // R9: size code 3 is never produced
  a_r9_size_code: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_size != 2'd3);
endmodule

// File: tb/opc_predecode_tb.sv
module opc_predecode_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode64 = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_byte = 8'h00;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [3:0] out_class;
  logic [3:0] out_reg;
  logic [1:0] out_size;
  logic       out_invalid;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;   // 50 MHz

  opc_predecode u_dut (
    .clk(clk), .rst(rst), .mode64(mode64),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_class(out_class), .out_reg(out_reg),
    .out_size(out_size), .out_invalid(out_invalid)
  );

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic take(input string tag, input int ecls, input int ereg,
                      input int esz, input int einv);
    n_run++;
    if (!out_valid || out_class != ecls || out_reg != ereg ||
        out_size != esz || out_invalid != einv) begin
      n_fail++;
      $display("FAIL %s: v=%0d cls=%0d reg=%0d sz=%0d inv=%0d expected v=1 cls=%0d reg=%0d sz=%0d inv=%0d",
               tag, out_valid, out_class, out_reg, out_size, out_invalid,
               ecls, ereg, esz, einv);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  // single-byte opcode expectations, straight from the requirement list
  function automatic void exp_single(input bit m, input logic [7:0] b,
                                     output int c, output int r, output int inv,
                                     output string tag);
    c = 0; r = 0; inv = 0; tag = "R13";
    if (!m && b >= 8'h40 && b <= 8'h4F) begin
      c = (b >= 8'h48) ? 2 : 1; r = b % 8; tag = "R1";
    end else if (b == 8'h06 || b == 8'h0E || b == 8'h16 || b == 8'h1E) begin
      c = 5; r = b / 8; inv = m; tag = "R5";
    end else if (b == 8'h07 || b == 8'h17 || b == 8'h1F) begin
      c = 6; r = b / 8; inv = m; tag = "R5";
    end else if (b == 8'h27 || b == 8'h2F || b == 8'h37 || b == 8'h3F ||
                 b == 8'hD4 || b == 8'hD5) begin
      c = 9; inv = m; tag = "R7";
    end else if (b == 8'h9E) begin
      c = 7; tag = "R8";
    end else if (b == 8'h9F) begin
      c = 8; tag = "R8";
    end
  endfunction

  initial begin
    #(20 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int c, r, inv;
    string tag;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 reset out_valid", out_valid == 1'b0, out_valid, 0);
    check("R12 reset in_ready", in_ready == 1'b1, in_ready, 1);

    // single-byte sweep, both modes (R1 R5 R7 R8 R13)
    for (int m = 0; m < 2; m++) begin
      mode64 = m[0];
      for (int b = 0; b < 256; b++) begin
        if (b == 8'h0F || b == 8'hFF || b == 8'h63 || b == 8'h66) continue;
        if (m == 1 && b >= 8'h40 && b <= 8'h4F) continue;
        send(b[7:0]);
        exp_single(m[0], b[7:0], c, r, inv, tag);
        take(tag, c, r, 1, inv);
      end
    end

    // R9: operand-size prefix in legacy mode on INC/DEC
    mode64 = 1'b0;
    for (int k = 0; k < 16; k++) begin
      send(8'h66);
      check("R9 prefix no record", out_valid == 1'b0, out_valid, 0);
      send(8'h40 + k[7:0]);
      take("R9", (k >= 8) ? 2 : 1, k % 8, 0, 0);
    end

    // R3: 0xFF group over every ModRM, both modes
    for (int m = 0; m < 2; m++) begin
      mode64 = m[0];
      for (int mb = 0; mb < 256; mb++) begin
        send(8'hFF);
        check("R3 no early record", out_valid == 1'b0, out_valid, 0);
        send(mb[7:0]);
        c = ((mb / 8) % 8 == 0) ? 1 : (((mb / 8) % 8 == 1) ? 2 : 0);
        take("R3", c, mb % 8, 1, 0);
      end
    end

    // R2 / R9: every REX value ahead of 0xFF 0xC3 in long mode
    mode64 = 1'b1;
    for (int x = 0; x < 16; x++) begin
      send(8'h40 + x[7:0]);
      check("R2 rex no record", out_valid == 1'b0, out_valid, 0);
      check("R2 rex ready", in_ready == 1'b1, in_ready, 1);
      send(8'hFF);
      send(8'hC3);
      take("R2", 1, (x % 2) * 8 + 3, (x >= 8) ? 2 : 1, 0);
    end

    // R4: 0x63 in both modes
    mode64 = 1'b0;
    for (int mb = 0; mb < 256; mb++) begin
      send(8'h63);
      send(mb[7:0]);
      take("R4 arpl", 4, mb % 8, 0, 0);
    end
    mode64 = 1'b1;
    for (int mb = 0; mb < 256; mb++) begin
      send(8'h4C);             // W=1 R=1
      send(8'h63);
      send(mb[7:0]);
      take("R4 movsxd", 3, 8 + (mb / 8) % 8, 2, 0);
    end
    for (int mb = 0; mb < 64; mb++) begin
      send(8'h63);
      send(mb[7:0] * 8'd4);
      take("R4 movsxd32", 3, ((mb * 4) / 8) % 8, 1, 0);
    end

    // R6: escape byte sweep
    for (int m = 0; m < 2; m++) begin
      mode64 = m[0];
      for (int b = 0; b < 256; b++) begin
        send(8'h0F);
        send(b[7:0]);
        if (b == 8'hA0)      take("R6", 5, 4, 1, 0);
        else if (b == 8'hA8) take("R6", 5, 5, 1, 0);
        else if (b == 8'hA1) take("R6", 6, 4, 1, 0);
        else if (b == 8'hA9) take("R6", 6, 5, 1, 0);
        else                 take("R6 other", 0, 0, 1, 0);
      end
    end

    // R10: prefix ordering
    mode64 = 1'b1;
    send(8'h48); send(8'h66); send(8'h63); send(8'hC8);
    take("R10 rex then 66", 3, 1, 0, 0);
    send(8'h66); send(8'h48); send(8'h63); send(8'hC8);
    take("R10 66 then rex", 3, 1, 2, 0);
    send(8'h41); send(8'h66); send(8'hFF); send(8'hC0);
    take("R10 rex.b dropped", 1, 0, 0, 0);
    send(8'h48); send(8'h41); send(8'hFF); send(8'hC0);
    take("R10 second rex wins", 1, 8, 1, 0);

    // R11: hold while not accepted; bytes offered meanwhile are not taken
    mode64 = 1'b0;
    send(8'h9E);
    @(negedge clk);
    in_valid = 1'b1; in_byte = 8'h48;
    repeat (3) @(negedge clk);
    check("R11 held valid", out_valid == 1'b1, out_valid, 1);
    check("R11 ready low", in_ready == 1'b0, in_ready, 0);
    check("R11 class stable", out_class == 4'd7, out_class, 7);
    in_valid = 1'b0;
    take("R11", 7, 0, 1, 0);
    check("R11 byte not consumed", out_valid == 1'b0, out_valid, 0);

    // R12: reset in the middle of an instruction
    mode64 = 1'b1;
    send(8'h66); send(8'h48); send(8'hFF);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 mid reset out_valid", out_valid == 1'b0, out_valid, 0);
    send(8'h63); send(8'hC8);
    take("R12 clean restart", 3, 1, 1, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule